// File: doc/BRIEF.md
# Chip-Striped Line Store with Checksum Detection and Parity Rebuild

This block holds cache lines spread across a set of data chips, one whole line per chip at a given index. A further chip holds, for every index, the XOR of the data lines of all data chips at that index. Each stored line carries an 8-bit checksum. The checksum only detects errors. The cross-chip parity repairs them. As a result, a failure that wipes out one chip's contents can be survived while a normal read touches only one chip.

A requester issues one request at a time through a valid/ready handshake. The request is a line write, a line read, or a fault injection. A fault injection overwrites a chip's raw line without updating its checksum or the parity, which models a chip that has gone bad. A read whose checksum matches returns at once. A read whose checksum fails reads the same index from every other chip and from the parity chip. The line is rebuilt, checked again against the stored checksum, and either written back and returned with a corrected flag, or returned with an uncorrectable flag. Every memory starts at all zeros, which is a consistent state because a zero line has a zero checksum.

Top module: `line_parity_guard`

## Requirements
- R1: While reset is held and right after it is released, `req_ready` is 1 and `rsp_valid`, `rsp_corrected`, `rsp_uncorr` and `rsp_rdata` are 0.
- R2: Op code 01 (write) stores the line with a checksum equal to the XOR of all its bytes. If the stored checksum of the old line matches, `rsp_valid` rises 2 cycles after acceptance with data 0 and both flags 0.
- R3: Op codes 00 and 11 (read) of a line whose checksum matches return the stored line 2 cycles after acceptance, with both flags 0.
- R4: Op code 10 (fault) replaces only the raw line. The checksum and the parity stay as they were. It responds 2 cycles after acceptance with data 0 and flags 0.
- R5: A read whose checksum fails responds 3 cycles after acceptance. It returns the parity line XORed with the same-index lines of the other data chips. When that result matches the stored checksum, `rsp_corrected` is 1.
- R6: A corrected line is written back to its chip, so the next read of that line takes the 2-cycle path with no flag.
- R7: When the rebuilt line fails the checksum, the response carries `rsp_uncorr`=1, `rsp_corrected`=0 and the rebuilt value, and nothing is written back.
- R8: Each write whose old line is intact updates the parity as old parity XOR old line XOR new line. Any single corrupted chip at that index can then still be rebuilt.
- R9: A write over a line whose stored checksum fails responds in 3 cycles. It sets the parity to the XOR of the other chips' lines and the new line.
- R10: When every line of one chip is corrupted, each line of that chip is recovered.
- R11: `req_ready` is 0 from the cycle after acceptance until the response cycle, so at most one request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 00/11 read, 01 write, 10 fault injection |
| req_chip | input | CHIP_W | Data chip holding the line |
| req_idx | input | IDX_W | Line index within the chip |
| req_wdata | input | LINE_BYTES*8 | Line for write or fault |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | LINE_BYTES*8 | Read data, 0 for write and fault |
| rsp_corrected | output | 1 | Line was rebuilt and repaired |
| rsp_uncorr | output | 1 | Rebuilt line failed its checksum |

## Verification
The bench checks that a repaired line is written back: it reads the same line twice. A design that skips the write-back shows a second 3-cycle, corrected read. It writes over a corrupted line and then corrupts a neighbour at the same index. A design that updates parity from the bad old data then returns wrong data for the neighbour. It corrupts two chips at one index, which must give an uncorrectable response twice in a row, and not silently wrong data. It also wipes a whole chip and catches any rebuild that leaves out a chip or wrongly includes the failing chip itself.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_FAULT  = 2'd2,
    OP_READ_B = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LOOK    = 2'd1,
    ST_REBUILD = 2'd2
  } st_e;
endpackage

// File: rtl/lp_csum.sv
module lp_csum #(
  parameter int BYTES = 64
) (
  input  logic [BYTES*8-1:0] line,
  output logic [7:0]         sum
);
  always_comb begin
    sum = '0;
    for (int b = 0; b < BYTES; b++) sum = sum ^ line[b*8 +: 8];
  end
endmodule

// File: rtl/lp_bank.sv
module lp_bank #(
  parameter int W     = 520,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data
);
  logic [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/line_parity_guard.sv
module line_parity_guard
  import lp_pkg::*;
#(
  parameter int CHIPS      = 8,
  parameter int LINE_BYTES = 64,
  parameter int DEPTH      = 16,
  localparam int CHIP_W    = $clog2(CHIPS),
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [CHIP_W-1:0] req_chip,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [LINE_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [LINE_W-1:0] rsp_rdata,
  output logic              rsp_corrected,
  output logic              rsp_uncorr
);
  localparam int WORD_W = LINE_W + 8;

  st_e               state;
  op_e               op_q;
  logic [CHIP_W-1:0] chip_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LINE_W-1:0] wdata_q;

  logic              accept;
  logic [CHIPS:0]    rd_en;
  logic [IDX_W-1:0]  rd_addr;
  logic [WORD_W-1:0] dword [CHIPS];
  logic [LINE_W-1:0] pword;
  logic [CHIPS-1:0]  tgt_hot;
  logic [CHIPS-1:0]  data_we;
  logic [WORD_W-1:0] data_wd;
  logic              par_we;
  logic [LINE_W-1:0] par_wd;

  logic [WORD_W-1:0] tgt_word;
  logic [LINE_W-1:0] tgt_data;
  logic [7:0]        tgt_ck;
  logic [LINE_W-1:0] others_x;
  logic [LINE_W-1:0] rebuilt;
  logic [7:0]        ck_tgt, ck_new, ck_rec;
  logic              tgt_ok, rec_ok, is_read, need_rebuild;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_addr   = (state == ST_IDLE) ? req_idx : idx_q;
  assign is_read   = (op_q == OP_READ) || (op_q == OP_READ_B);

  // one bank per data chip, checksum kept beside the line
  for (genvar c = 0; c < CHIPS; c++) begin : g_data
    lp_bank #(.W(WORD_W), .DEPTH(DEPTH), .AW(IDX_W)) u_bank (
      .clk     (clk),
      .rd_en   (rd_en[c]),
      .rd_addr (rd_addr),
      .rd_data (dword[c]),
      .wr_en   (data_we[c]),
      .wr_addr (idx_q),
      .wr_data (data_wd)
    );
  end

  lp_bank #(.W(LINE_W), .DEPTH(DEPTH), .AW(IDX_W)) u_par_bank (
    .clk     (clk),
    .rd_en   (rd_en[CHIPS]),
    .rd_addr (rd_addr),
    .rd_data (pword),
    .wr_en   (par_we),
    .wr_addr (idx_q),
    .wr_data (par_wd)
  );

  always_comb begin
    tgt_word = '0;
    others_x = '0;
    for (int c = 0; c < CHIPS; c++) begin
      tgt_hot[c] = (CHIP_W'(c) == chip_q);
      if (tgt_hot[c]) tgt_word = dword[c];
      else            others_x = others_x ^ dword[c][LINE_W-1:0];
    end
  end

  assign tgt_data = tgt_word[LINE_W-1:0];
  assign tgt_ck   = tgt_word[WORD_W-1:LINE_W];
  assign rebuilt  = others_x ^ pword;

  lp_csum #(.BYTES(LINE_BYTES)) u_ck_tgt (.line(tgt_data), .sum(ck_tgt));
  lp_csum #(.BYTES(LINE_BYTES)) u_ck_new (.line(wdata_q),  .sum(ck_new));
  lp_csum #(.BYTES(LINE_BYTES)) u_ck_rec (.line(rebuilt),  .sum(ck_rec));

  assign tgt_ok       = (ck_tgt == tgt_ck);
  assign rec_ok       = (ck_rec == tgt_ck);
  assign need_rebuild = (state == ST_LOOK) && !tgt_ok && (op_q != OP_FAULT);

  // read enables: one chip (plus parity for writes) on entry, the rest on a miss
  always_comb begin
    rd_en = '0;
    if (accept) begin
      for (int c = 0; c < CHIPS; c++)
        if (CHIP_W'(c) == req_chip) rd_en[c] = 1'b1;
      if (req_op == 2'(OP_WRITE)) rd_en[CHIPS] = 1'b1;
    end else if (need_rebuild) begin
      rd_en = '1;
      for (int c = 0; c < CHIPS; c++)
        if (tgt_hot[c]) rd_en[c] = 1'b0;
    end
  end

  // bank writes
  always_comb begin
    data_we = '0;
    data_wd = '0;
    par_we  = 1'b0;
    par_wd  = '0;
    case (state)
      ST_LOOK: begin
        if (op_q == OP_WRITE && tgt_ok) begin
          data_we = tgt_hot;
          data_wd = {ck_new, wdata_q};
          par_we  = 1'b1;
          par_wd  = pword ^ tgt_data ^ wdata_q;
        end else if (op_q == OP_FAULT) begin
          data_we = tgt_hot;
          data_wd = {tgt_ck, wdata_q};
        end
      end
      ST_REBUILD: begin
        if (is_read && rec_ok) begin
          data_we = tgt_hot;
          data_wd = {tgt_ck, rebuilt};
        end else if (op_q == OP_WRITE) begin
          data_we = tgt_hot;
          data_wd = {ck_new, wdata_q};
          par_we  = 1'b1;
          par_wd  = others_x ^ wdata_q;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      op_q          <= OP_READ;
      chip_q        <= '0;
      idx_q         <= '0;
      wdata_q       <= '0;
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_corrected <= 1'b0;
      rsp_uncorr    <= 1'b0;
    end else begin
      rsp_valid     <= 1'b0;
      rsp_corrected <= 1'b0;
      rsp_uncorr    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= op_e'(req_op);
            chip_q  <= req_chip;
            idx_q   <= req_idx;
            wdata_q <= req_wdata;
            state   <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (need_rebuild) begin
            state <= ST_REBUILD;
          end else begin
            rsp_valid <= 1'b1;
            rsp_rdata <= is_read ? tgt_data : '0;
            state     <= ST_IDLE;
          end
        end
        ST_REBUILD: begin
          rsp_valid     <= 1'b1;
          rsp_rdata     <= is_read ? rebuilt : '0;
          rsp_corrected <= is_read && rec_ok;
          rsp_uncorr    <= is_read && !rec_ok;
          state         <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);
  a_r11_single_response: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rsp_corrected && rsp_uncorr));
  a_r5_flags_need_response: assert property (@(posedge clk) disable iff (rst)
    (rsp_corrected || rsp_uncorr) |-> rsp_valid);
  a_r3_fast_path_clean: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(state) == ST_LOOK) |-> (!rsp_corrected && !rsp_uncorr));
  a_r6_repair_from_rebuild: assert property (@(posedge clk) disable iff (rst)
    rsp_corrected |-> ($past(state) == ST_REBUILD));
endmodule

// File: tb/line_parity_guard_tb.sv
`timescale 1ns/1ps
module line_parity_guard_tb;
  localparam int CHIPS = 8;
  localparam int LB    = 64;
  localparam int DEPTH = 16;
  localparam int LW    = LB * 8;
  localparam int NV    = 17;

  // {op[1:0], chip[2:0], idx[3:0], seed[7:0]}
  localparam logic [16:0] VEC [NV] = '{
    {2'd1, 3'd0, 4'd1, 8'd11}, {2'd1, 3'd1, 4'd1, 8'd22},
    {2'd1, 3'd2, 4'd1, 8'd33}, {2'd1, 3'd7, 4'd1, 8'd44},
    {2'd0, 3'd1, 4'd1, 8'd0},  {2'd1, 3'd1, 4'd1, 8'd55},
    {2'd0, 3'd1, 4'd1, 8'd0},  {2'd2, 3'd2, 4'd1, 8'd3},
    {2'd0, 3'd2, 4'd1, 8'd0},  {2'd0, 3'd2, 4'd1, 8'd0},
    {2'd2, 3'd0, 4'd1, 8'd0},  {2'd1, 3'd0, 4'd1, 8'd66},
    {2'd0, 3'd0, 4'd1, 8'd0},  {2'd2, 3'd7, 4'd1, 8'd63},
    {2'd0, 3'd7, 4'd1, 8'd0},  {2'd0, 3'd3, 4'd1, 8'd0},
    {2'd3, 3'd1, 4'd1, 8'd0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [2:0]    req_chip = '0;
  logic [3:0]    req_idx = '0;
  logic [LW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [LW-1:0] rsp_rdata;
  logic          rsp_corrected;
  logic          rsp_uncorr;

  int n_chk  = 0;
  int n_fail = 0;

  logic [LW-1:0] m_data [CHIPS][DEPTH];
  logic [7:0]    m_ck   [CHIPS][DEPTH];
  logic [LW-1:0] m_par  [DEPTH];

  always #2.5 clk = ~clk;

  line_parity_guard #(.CHIPS(CHIPS), .LINE_BYTES(LB), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_chip(req_chip), .req_idx(req_idx), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_corrected(rsp_corrected), .rsp_uncorr(rsp_uncorr)
  );

  function automatic logic [7:0] csum(input logic [LW-1:0] d);
    logic [7:0] s = '0;
    for (int b = 0; b < LB; b++) s = s ^ d[b*8 +: 8];
    return s;
  endfunction

  function automatic logic [LW-1:0] pat(input int seed);
    logic [LW-1:0] d;
    for (int b = 0; b < LB; b++) d[b*8 +: 8] = 8'((seed * 37) ^ (b * 11) ^ (seed >> 2) ^ b);
    return d;
  endfunction

  function automatic logic [LW-1:0] flip(input logic [LW-1:0] d, input int pos);
    logic [LW-1:0] r = d;
    r[(pos % LB)*8 +: 8] = r[(pos % LB)*8 +: 8] ^ 8'h5A;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input int op, input int chip, input int idx, input logic [LW-1:0] d,
                       output logic [LW-1:0] rd, output logic corr, output logic unc,
                       output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_chip = 3'(chip);
    req_idx = 4'(idx); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R11", "ready after accept", LW'(req_ready), '0);
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata; corr = rsp_corrected; unc = rsp_uncorr;
  endtask

  task automatic run_op(input int op, input int chip, input int idx, input logic [LW-1:0] d);
    logic [LW-1:0] rd, exp_d, oth, rb;
    logic corr, unc, e_corr, e_unc;
    int lat, e_lat;
    string tag;
    oth = '0;
    for (int c = 0; c < CHIPS; c++) if (c != chip) oth = oth ^ m_data[c][idx];
    e_corr = 1'b0; e_unc = 1'b0; exp_d = '0; e_lat = 2;
    if (op == 1) begin
      if (csum(m_data[chip][idx]) == m_ck[chip][idx]) begin
        tag = "R2";
        m_par[idx] = m_par[idx] ^ m_data[chip][idx] ^ d;
      end else begin
        tag = "R9"; e_lat = 3;
        m_par[idx] = oth ^ d;
      end
      m_data[chip][idx] = d;
      m_ck[chip][idx] = csum(d);
    end else if (op == 2) begin
      tag = "R4";
      m_data[chip][idx] = d;
    end else begin
      if (csum(m_data[chip][idx]) == m_ck[chip][idx]) begin
        tag = "R3"; exp_d = m_data[chip][idx];
      end else begin
        e_lat = 3;
        rb = oth ^ m_par[idx];
        exp_d = rb;
        if (csum(rb) == m_ck[chip][idx]) begin
          tag = "R5"; e_corr = 1'b1;
          m_data[chip][idx] = rb;
        end else begin
          tag = "R7"; e_unc = 1'b1;
        end
      end
    end
    do_op(op, chip, idx, d, rd, corr, unc, lat);
    check(lat == e_lat, tag, "latency", LW'(lat), LW'(e_lat));
    check(rd == exp_d, tag, "data", rd, exp_d);
    check(corr == e_corr, tag, "corrected flag", LW'(corr), LW'(e_corr));
    check(unc == e_unc, tag, "uncorrectable flag", LW'(unc), LW'(e_unc));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R11: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [LW-1:0] rd;
    logic corr, unc;
    int lat;
    for (int c = 0; c < CHIPS; c++)
      for (int i = 0; i < DEPTH; i++) begin
        m_data[c][i] = '0; m_ck[c][i] = '0;
      end
    for (int i = 0; i < DEPTH; i++) m_par[i] = '0;

    repeat (3) @(negedge clk);
    // R1: values while reset is held
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "ready/valid in reset",
          LW'({req_ready, rsp_valid}), LW'(2'b10));
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", LW'(req_ready), LW'(1));
    check(!rsp_valid && !rsp_corrected && !rsp_uncorr, "R1", "flags after reset",
          LW'({rsp_valid, rsp_corrected, rsp_uncorr}), '0);
    check(rsp_rdata == '0, "R1", "data after reset", rsp_rdata, '0);

    // table walk: R2 R3 R4 R5 R6 R8 R9 paths
    for (int v = 0; v < NV; v++) begin
      int op, ch, ix, sd;
      logic [LW-1:0] d;
      op = int'(VEC[v][16:15]); ch = int'(VEC[v][14:12]);
      ix = int'(VEC[v][11:8]);  sd = int'(VEC[v][7:0]);
      if (op == 1)      d = pat(sd);
      else if (op == 2) d = flip(m_data[ch][ix], sd);
      else              d = '0;
      run_op(op, ch, ix, d);
    end

    // R6: repaired line takes fast path with no flag
    run_op(2, 4, 1, flip(m_data[4][1], 9));
    run_op(0, 4, 1, '0);
    do_op(0, 4, 1, '0, rd, corr, unc, lat);
    check(lat == 2 && !corr && !unc, "R6", "re-read after repair",
          LW'({lat[3:0], corr, unc}), LW'({4'd2, 2'b00}));
    check(rd == m_data[4][1], "R6", "re-read data", rd, m_data[4][1]);

    // R10: fill every chip, then wipe chip 5 entirely
    for (int c = 0; c < CHIPS; c++)
      for (int i = 0; i < DEPTH; i++) run_op(1, c, i, pat(c * 16 + i + 3));
    for (int i = 0; i < DEPTH; i++) run_op(2, 5, i, ~m_data[5][i] ^ pat(200 + i));
    for (int i = 0; i < DEPTH; i++) begin
      do_op(0, 5, i, '0, rd, corr, unc, lat);
      check(rd == pat(5 * 16 + i + 3) && corr && !unc, "R10", "whole-chip recovery",
            rd, pat(5 * 16 + i + 3));
      m_data[5][i] = pat(5 * 16 + i + 3);
    end

    // R8: incremental parity after rewrites, then rebuild a different chip
    run_op(1, 6, 7, pat(91));
    run_op(1, 2, 7, pat(92));
    run_op(2, 3, 7, flip(m_data[3][7], 20));
    run_op(0, 3, 7, '0);
    check(m_data[3][7] == pat(3 * 16 + 7 + 3), "R8", "model rebuild value",
          m_data[3][7], pat(3 * 16 + 7 + 3));

    // R7: two chips bad at one index -> uncorrectable, no write-back
    run_op(2, 1, 4, flip(m_data[1][4], 5));
    run_op(2, 2, 4, flip(m_data[2][4], 6));
    run_op(0, 1, 4, '0);
    do_op(0, 1, 4, '0, rd, corr, unc, lat);
    check(unc && !corr && lat == 3, "R7", "repeat uncorrectable read",
          LW'({lat[3:0], corr, unc}), LW'({4'd3, 2'b01}));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule